// File: doc/BRIEF.md
# Performance Event Counter Bank

The block holds a small set of wide event counters and one control register. It is meant to sit next to a processor pipeline. Each counter watches its own one-cycle event pulse. It advances only while its enable bit is set, counting is not frozen or held off, and the current privilege level is allowed to count. Software reaches every counter, the control register and a captured-address register through a plain register bus. A write lands on the next clock edge. A read is combinational.

Software sets the sampling period by preloading a counter so that the counter's top bit becomes set after the chosen number of events. The interrupt-enabled counter whose increment sets that bit raises an overflow. On that edge the block stores the instruction address that is presented on that cycle. It also marks the sample as valid and sets a hold-off bit, which stops all counting until a return-from-interrupt pulse. The interrupt line stays high while any interrupt-enabled counter still has its top bit set, so the handler lowers it by rewriting those counters.

All pins are plain level or pulse signals. The block has no streaming traffic, so there is no valid/ready handshake and no back-pressure.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every counter, the control register and the captured address read as zero, and `irq_o` is low.
- R2: Counter i (0 to 5) adds one on a clock edge where `event_i[i]` is high and counting is allowed. Counting is allowed only if control bit i is set, bit 8 is clear, bit 9 is clear and the privilege check passes. In every other case the counter keeps its value, apart from bus writes.
- R3: The privilege check uses `priv_i` and one control bit per level. Code 0 (user) needs control bit 20. Code 1 (supervisor) needs bit 21. Codes 2 and 3 (hypervisor) need bit 22.
- R4: While control bit 8 (freeze) is set, no counter changes except through bus writes.
- R5: While control bit 9 (hold-off) is set, no counter advances. A `rfi_i` pulse clears bit 9 on the next edge, unless an overflow or a control write occurs on that same edge. Counting resumes on the following cycle.
- R6: An overflow occurs when an increment takes counter i from 0x7F_FFFF_FFFF to 0x80_0000_0000 while control bit 12+i is set. On that edge the block sets control bits 9 (hold-off) and 10 (sample valid) and captures `pc_i` into the captured-address register.
- R7: `irq_o` is high exactly when some counter i has bit 39 set and control bit 12+i is set. Rewriting the counter with bit 39 clear lowers `irq_o` on the next cycle.
- R8: A bus write takes effect on the next edge. On the same edge it wins over an increment of the written counter. A write to the control register replaces the whole register, overriding any overflow or `rfi_i` update on that edge.
- R9: Bus addresses 0 to 5 select counters 0 to 5, address 6 selects the control register (32 bits, zero-extended) and address 7 selects the captured address. Writes to address 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 6 | One-cycle event pulse per counter |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 2/3 hypervisor) |
| rfi_i | input | 1 | Return-from-interrupt pulse |
| pc_i | input | 40 | Instruction address offered for capture |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 40 | Register write data |
| bus_rdata | output | 40 | Register read data (combinational) |
| irq_o | output | 1 | Overflow interrupt request (level) |

## Verification
The assertions assume that reset is applied before any traffic. They also assume that every input is stable around the rising edge, and that a return-from-interrupt pulse and a counter event can arrive in any cycle. The bench drives all inputs half a period away from the edge and holds each pulse for exactly one cycle. Its random stimulus often preloads counters just below bit 39, and just below the 40-bit wrap, so that overflows, overflow-versus-write collisions and hold-off release happen many times. The control words it writes keep freeze and hold-off rare enough that the counters move most of the time.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // Control register geometry; bit positions are decoded by software
  localparam int CTL_W    = 32;
  localparam int EN_LSB   = 0;   // per-counter count enables
  localparam int FRZ_BIT  = 8;   // global freeze
  localparam int HOLD_BIT = 9;   // hold-off until return from interrupt
  localparam int SMP_BIT  = 10;  // captured address is valid
  localparam int IE_LSB   = 12;  // per-counter interrupt enables
  localparam int USR_BIT  = 20;
  localparam int SUP_BIT  = 21;
  localparam int HYP_BIT  = 22;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_HYPX = 2'd3
  } priv_e;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             inc,
  output logic [CNT_W-1:0] value,
  output logic             reach_top
);
  localparam logic [CNT_W-1:0] BELOW_TOP = {1'b0, {(CNT_W-1){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wr_data;
    else if (inc)   value <= value + 1'b1;
  end

  // Increment that sets the top bit this edge (suppressed by a write)
  assign reach_top = inc && !wr_en && (value == BELOW_TOP);

  // R8: bus write wins over an increment
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> value == $past(wr_data));

  // R2: a single step per event
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> value == CNT_W'($past(value) + 1'b1));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en) |=> $stable(value));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              rfi,
  input  logic              trig,
  input  logic [ADDR_W-1:0] pc,
  input  logic [1:0]        priv,
  output logic [CTL_W-1:0]  ctl,
  output logic [ADDR_W-1:0] sample_addr,
  output logic              count_ok
);
  logic priv_allow;

  always_comb begin
    unique case (priv_e'(priv))
      PRIV_USER: priv_allow = ctl[USR_BIT];
      PRIV_SUP:  priv_allow = ctl[SUP_BIT];
      default:   priv_allow = ctl[HYP_BIT];
    endcase
  end

  assign count_ok = priv_allow && !ctl[FRZ_BIT] && !ctl[HOLD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl <= wr_data;
    end else if (trig) begin
      ctl[HOLD_BIT] <= 1'b1;
      ctl[SMP_BIT]  <= 1'b1;
    end else if (rfi) begin
      ctl[HOLD_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sample_addr <= '0;
    else if (trig) sample_addr <= pc;
  end

  // R6: capture of the address and flags on overflow
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> sample_addr == $past(pc));

  a_r6_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !wr_en) |=> (ctl[HOLD_BIT] && ctl[SMP_BIT]));

  // R5: return from interrupt releases the hold-off
  a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi && !trig && !wr_en) |=> !ctl[HOLD_BIT]);

  // R8: control write replaces the whole register
  a_r8_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl == $past(wr_data));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_CNT = 6,   // at most 8 so enables stay below the freeze bit
  parameter int CNT_W   = 40,
  parameter int ADDR_W  = $clog2(NUM_CNT + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] event_i,
  input  logic [1:0]         priv_i,
  input  logic               rfi_i,
  input  logic [CNT_W-1:0]   pc_i,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] SMP_ADDR = ADDR_W'(NUM_CNT + 1);

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0]            reach_top;
  logic [NUM_CNT-1:0]            ovf_live;
  logic [CTL_W-1:0]              ctl_q;
  logic [CNT_W-1:0]              smp_q;
  logic                          count_ok;
  logic                          trig;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && (bus_addr == ADDR_W'(i))),
      .wr_data  (bus_wdata),
      .inc      (event_i[i] && ctl_q[EN_LSB+i] && count_ok),
      .value    (cnt_q[i]),
      .reach_top(reach_top[i])
    );
    assign ovf_live[i] = cnt_q[i][CNT_W-1] && ctl_q[IE_LSB+i];
  end

  assign trig  = |(reach_top & ctl_q[IE_LSB +: NUM_CNT]);
  assign irq_o = |ovf_live;

  pmc_ctrl #(.ADDR_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we && (bus_addr == CTL_ADDR)),
    .wr_data    (bus_wdata[CTL_W-1:0]),
    .rfi        (rfi_i),
    .trig       (trig),
    .pc         (pc_i),
    .priv       (priv_i),
    .ctl        (ctl_q),
    .sample_addr(smp_q),
    .count_ok   (count_ok)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTL_ADDR)      bus_rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
    else if (bus_addr == SMP_ADDR) bus_rdata = smp_q;
    else begin
      for (int k = 0; k < NUM_CNT; k++)
        if (bus_addr == ADDR_W'(k)) bus_rdata = cnt_q[k];
    end
  end

  // R4: frozen counters only move through the bus
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[FRZ_BIT] && !bus_we) |=> $stable(cnt_q));

  // R3: a disallowed privilege level blocks counting
  a_r3_priv_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !((priv_i == 2'd0) ? ctl_q[USR_BIT] :
                  (priv_i == 2'd1) ? ctl_q[SUP_BIT] : ctl_q[HYP_BIT]))
    |=> $stable(cnt_q));

  // R7: the request only rises through an overflow or a bus write
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !bus_we && !trig) |=> !irq_o);

  // R5: hold-off keeps counters still
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[HOLD_BIT] && !bus_we) |=> $stable(cnt_q));
endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/100ps
module test_pmc_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  event_i = '0;
  logic [1:0]  priv_i = '0;
  logic        rfi_i = 1'b0;
  logic [39:0] pc_i = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [39:0] bus_wdata = '0;
  logic [39:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [39:0] m_cnt [6];
  logic [31:0] m_ctl;
  logic [39:0] m_smp;

  always #5 clk = ~clk;

  pmc_bank i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .priv_i(priv_i),
    .rfi_i(rfi_i), .pc_i(pc_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit m_priv_ok(input logic [1:0] pr);
    if (pr == 2'd0) return m_ctl[20];
    if (pr == 2'd1) return m_ctl[21];
    return m_ctl[22];
  endfunction

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int i = 0; i < 6; i++) r |= m_cnt[i][39] & m_ctl[12+i];
    return r;
  endfunction

  function automatic logic [39:0] m_read(input logic [2:0] a);
    if (a == 3'd6) return {8'd0, m_ctl};
    if (a == 3'd7) return m_smp;
    return m_cnt[a];
  endfunction

  task automatic tick(input logic [5:0] ev, input logic [1:0] pr, input logic rf,
                      input logic [39:0] pc, input logic we, input logic [2:0] wa,
                      input logic [39:0] wd);
    logic [39:0] n_cnt [6];
    logic [31:0] n_ctl;
    logic [39:0] n_smp;
    bit ok, trg;
    @(negedge clk);
    event_i = ev; priv_i = pr; rfi_i = rf; pc_i = pc;
    bus_we = we; bus_addr = wa; bus_wdata = wd;
    ok = m_priv_ok(pr) && !m_ctl[8] && !m_ctl[9];
    trg = 1'b0;
    for (int i = 0; i < 6; i++) begin
      bit inc = ev[i] && m_ctl[i] && ok;
      n_cnt[i] = m_cnt[i];
      if (we && wa == 3'(i)) n_cnt[i] = wd;
      else if (inc) begin
        n_cnt[i] = m_cnt[i] + 40'd1;
        if (m_ctl[12+i] && m_cnt[i] == 40'h7F_FFFF_FFFF) trg = 1'b1;
      end
    end
    n_ctl = m_ctl;
    if (we && wa == 3'd6) n_ctl = wd[31:0];
    else if (trg) begin n_ctl[9] = 1'b1; n_ctl[10] = 1'b1; end
    else if (rf) n_ctl[9] = 1'b0;
    n_smp = trg ? pc : m_smp;
    @(posedge clk);
    for (int i = 0; i < 6; i++) m_cnt[i] = n_cnt[i];
    m_ctl = n_ctl; m_smp = n_smp;
    #1;
    event_i = '0; rfi_i = 1'b0; bus_we = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #0.4;
      check(tag, bus_rdata, m_read(3'(a)));
    end
    check({tag, " irq"}, {39'd0, irq_o}, {39'd0, m_irq()});
  endtask

  task automatic rd(input logic [2:0] a, output logic [39:0] v);
    bus_addr = a;
    #0.4;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [39:0] d);
    tick(6'd0, priv_i, 1'b0, 40'd0, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [39:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) m_cnt[i] = '0;
    m_ctl = '0; m_smp = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    compare_all("R1 reset");

    // R2: basic counting, disabled counter stays put
    wr(3'd6, 40'h10_0001);                       // en0 | user
    wr(3'd0, 40'd5);
    repeat (3) tick(6'b000011, 2'd0, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R2 counter0 counts", v, 40'd8);
    rd(3'd1, v); check("R2 disabled counter1", v, 40'd0);

    // R3: supervisor not enabled, then enabled
    tick(6'b000001, 2'd1, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R3 supervisor blocked", v, 40'd8);
    wr(3'd6, 40'h20_0001);                       // en0 | supervisor
    tick(6'b000001, 2'd1, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R3 supervisor allowed", v, 40'd9);
    tick(6'b000001, 2'd3, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R3 hypervisor blocked", v, 40'd9);

    // R4: freeze
    wr(3'd6, 40'h10_0101);                       // en0 | user | freeze
    tick(6'b000001, 2'd0, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R4 frozen", v, 40'd9);

    // R5: hold-off and release
    wr(3'd6, 40'h10_0201);                       // en0 | user | hold
    tick(6'b000001, 2'd0, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R5 held", v, 40'd9);
    tick(6'b000001, 2'd0, 1'b1, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd6, v); check("R5 rfi clears hold", v, 40'h10_0001);
    tick(6'b000001, 2'd0, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R5 counting resumes", v, 40'd10);

    // R6 / R7: overflow
    wr(3'd6, 40'h10_1001);                       // en0 | ie0 | user
    wr(3'd0, 40'h7F_FFFF_FFFF);
    check("R7 no irq before overflow", {39'd0, irq_o}, 40'd0);
    tick(6'b000001, 2'd0, 1'b0, 40'h00_000A_BCDE, 1'b0, 3'd0, 40'd0);
    check("R7 irq raised", {39'd0, irq_o}, 40'd1);
    rd(3'd6, v); check("R6 hold and sample flags", v, 40'h10_1601);
    rd(3'd7, v); check("R6 captured address", v, 40'h00_000A_BCDE);
    tick(6'b000001, 2'd0, 1'b0, 40'd0, 1'b0, 3'd0, 40'd0);
    rd(3'd0, v); check("R6 hold after overflow", v, 40'h80_0000_0000);
    wr(3'd0, 40'd0);
    check("R7 irq cleared by rewrite", {39'd0, irq_o}, 40'd0);

    // R8: write beats increment; control write beats rfi
    wr(3'd6, 40'h10_0201);
    tick(6'b000001, 2'd0, 1'b1, 40'd0, 1'b1, 3'd6, 40'h10_0201);
    rd(3'd6, v); check("R8 control write beats rfi", v, 40'h10_0201);
    wr(3'd6, 40'h10_0001);
    tick(6'b000001, 2'd0, 1'b0, 40'd0, 1'b1, 3'd0, 40'd100);
    rd(3'd0, v); check("R8 write beats increment", v, 40'd100);

    // R9: captured-address register is read-only
    wr(3'd7, 40'd123);
    rd(3'd7, v); check("R9 address write ignored", v, 40'h00_000A_BCDE);
    compare_all("R9 map");

    // Random phase
    for (int n = 0; n < 600; n++) begin
      logic [39:0] wd;
      logic [2:0]  wa;
      bit          we;
      int          r = $urandom_range(0, 15);
      we = (r < 3);
      wa = 3'($urandom_range(0, 7));
      wd = {8'($urandom), 32'($urandom)};
      if (we && wa == 3'd6) begin
        wd = '0;
        wd[5:0]   = 6'($urandom);
        wd[17:12] = 6'($urandom);
        wd[8]     = ($urandom_range(0, 7) == 0);
        wd[9]     = ($urandom_range(0, 5) == 0);
        wd[22:20] = 3'($urandom) | 3'b001;
      end else if (we && wa < 3'd6) begin
        case ($urandom_range(0, 3))
          0: wd = 40'h7F_FFFF_FFF0 + 40'($urandom_range(0, 15));
          1: wd = 40'hFF_FFFF_FFFC + 40'($urandom_range(0, 3));
          default: ;
        endcase
      end
      tick(6'($urandom), 2'($urandom), ($urandom_range(0, 9) == 0),
           {8'($urandom), 32'($urandom)}, we, wa, wd);
      compare_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule